// File: doc/BRIEF.md
# Flash Block Write-Protection Lock Manager

This block holds a protection state for every erase block of a flash array whose block count is a parameter. Each block is in one of three states: unlocked, locked, or lock-tight. Lock-tight is a locked state that the unlock and lock commands cannot change, so it holds until the next cold reset. Software first sets an inclusive range with a start-index register and an end-index register. It then issues a command strobe with an opcode, and the block walks the range one block per clock and applies the command.

The walk follows a fixed set of rules. An unlock or lock walk halts at the first lock-tight block it meets. A lock-tight walk passes over blocks that are unlocked. An index past the last real block raises a command-error flag and ends the walk. Each block that is rewritten also puts its new encoding into a write-protection status register. A one-cycle done pulse marks the end of every walk. A separate query port lets the rest of the chip read the state of any block at any time.

Top module: `wp_lock_mgr`

## Requirements
- R1: State encodings are lock-tight = 3'b001, locked = 3'b010, unlocked = 3'b100. While and after a cold reset (rst_n low), every block reads locked, wp_status is 16'h0002, both range indices are 0, and walk_done and cmd_err are 0. A query index at or beyond NUM_BLOCKS reads 3'b000.
- R2: A start-index write (lo_we) stores range_wdata reduced to its low IDX_W bits, where IDX_W = clog2(NUM_BLOCKS). It loads that value into both range_lo and range_hi. An end-index write (hi_we) changes only range_hi. For a power-of-two block count this reduction is a mask with NUM_BLOCKS-1.
- R3: Opcode 8'h23 unlocks blocks range_lo through range_hi inclusive. If range_hi < range_lo, no block changes.
- R4: Opcode 8'h2A locks blocks range_lo through range_hi inclusive.
- R5: Opcode 8'h27 unlocks from block 0 through block NUM_BLOCKS-1, whatever the range registers hold.
- R6: During an unlock, unlock-all or lock walk, the first lock-tight block ends the walk and is left unchanged. Blocks after it are not visited.
- R7: Opcode 8'h2C makes blocks in the range lock-tight. Unlocked blocks are skipped and the walk goes on. Blocks that are already lock-tight are written again.
- R8: A walk that reaches an index at or above NUM_BLOCKS sets cmd_err and ends there. cmd_err stays set until the next accepted command clears it.
- R9: Each block written by a walk also loads its new encoding, zero-extended to 16 bits, into wp_status. Skipped or stopping blocks leave wp_status unchanged.
- R10: The walk evaluates one block per clock. Stepping past range_hi, a stop, or an error each costs one evaluation. walk_done is high for exactly one cycle, in the cycle after the last evaluation. So with the command sampled at edge A, and n evaluations, done is high after edge A+n.
- R11: A command strobe that arrives while a walk is running is ignored. An opcode other than the four above starts no walk, raises no done, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low, asynchronous |
| lo_we | input | 1 | Write strobe for the start index (also loads the end index) |
| hi_we | input | 1 | Write strobe for the end index |
| range_wdata | input | RANGE_W | Data for range index writes |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| query_idx | input | IDX_W | Block index to query |
| query_state | output | 3 | Protection encoding of the queried block |
| range_lo | output | IDX_W | Current start index |
| range_hi | output | IDX_W | Current end index |
| wp_status | output | 16 | Write-protection status register |
| walk_done | output | 1 | One-cycle pulse at the end of a walk |
| cmd_err | output | 1 | Range ran past the array |

## Verification
The bench builds the block with NUM_BLOCKS = 12 and RANGE_W = 16. This gives a 4-bit index field in which indices 12 to 15 are storable but do not exist, so the command-error path can be reached from ordinary range writes. With only twelve blocks and sixteen index values, every start/end pair can be swept for each opcode, including reversed ranges. The unlock, lock and unlock-all pass runs first. A second pass after a fresh reset mixes in lock-tight commands, so that the stop and skip rules meet many lock patterns. An arithmetic model in the bench predicts the states, the status value, the error flag and the exact done latency of every command.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;

  localparam int OP_W   = 8;
  localparam int STAT_W = 16;

  typedef logic [2:0] wp_enc_t;

  localparam wp_enc_t ENC_TIGHT    = 3'b001;
  localparam wp_enc_t ENC_LOCKED   = 3'b010;
  localparam wp_enc_t ENC_UNLOCKED = 3'b100;

  localparam logic [OP_W-1:0] OP_UNLOCK     = 8'h23;
  localparam logic [OP_W-1:0] OP_UNLOCK_ALL = 8'h27;
  localparam logic [OP_W-1:0] OP_LOCK       = 8'h2A;
  localparam logic [OP_W-1:0] OP_TIGHT      = 8'h2C;

  typedef enum logic [1:0] {ACT_WRITE, ACT_SKIP, ACT_STOP} wp_act_e;

  // Opcodes that start a walk (R11)
  function automatic logic op_known(input logic [OP_W-1:0] op);
    return (op == OP_UNLOCK) || (op == OP_UNLOCK_ALL) ||
           (op == OP_LOCK)   || (op == OP_TIGHT);
  endfunction

  // Encoding a walk writes into a visited block
  function automatic wp_enc_t op_target(input logic [OP_W-1:0] op);
    case (op)
      OP_LOCK:  return ENC_LOCKED;
      OP_TIGHT: return ENC_TIGHT;
      default:  return ENC_UNLOCKED;
    endcase
  endfunction

  // Per-block decision: lock-tight halts unlock/lock (R6),
  // unlocked blocks are passed over by lock-tight (R7)
  function automatic wp_act_e op_action(input logic [OP_W-1:0] op,
                                        input wp_enc_t cur);
    case (op)
      OP_UNLOCK, OP_UNLOCK_ALL, OP_LOCK:
        return (cur == ENC_TIGHT) ? ACT_STOP : ACT_WRITE;
      OP_TIGHT:
        return (cur == ENC_UNLOCKED) ? ACT_SKIP : ACT_WRITE;
      default:
        return ACT_STOP;
    endcase
  endfunction

endpackage

// File: rtl/wp_range_regs.sv
module wp_range_regs #(
  parameter int NUM_BLOCKS = 16,
  parameter int RANGE_W    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lo_we,
  input  logic                   hi_we,
  input  logic [RANGE_W-1:0]     wdata,
  output logic [$clog2(NUM_BLOCKS)-1:0] lo_q,
  output logic [$clog2(NUM_BLOCKS)-1:0] hi_q
);
  localparam int IDX_W = $clog2(NUM_BLOCKS);

  // Reduce a written value to the index field (R2)
  function automatic logic [IDX_W-1:0] fold_index(input logic [RANGE_W-1:0] v);
    return v[IDX_W-1:0];
  endfunction

  logic [IDX_W-1:0] wr_idx;
  assign wr_idx = fold_index(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_we) begin
        lo_q <= wr_idx;
        hi_q <= wr_idx;
      end
      if (hi_we) begin
        hi_q <= wr_idx;
      end
    end
  end

endmodule

// File: rtl/wp_state_array.sv
module wp_state_array
  import wp_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(NUM_BLOCKS)-1:0] wr_idx,
  input  wp_enc_t                       wr_val,
  input  logic [$clog2(NUM_BLOCKS)-1:0] walk_idx,
  output wp_enc_t                       walk_state,
  input  logic [$clog2(NUM_BLOCKS)-1:0] query_idx,
  output wp_enc_t                       query_state,
  output logic [3*NUM_BLOCKS-1:0]       state_flat
);
  localparam int IDX_W = $clog2(NUM_BLOCKS);

  wp_enc_t st_q [NUM_BLOCKS];

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q[g] <= ENC_LOCKED;
      else if (hit) st_q[g] <= wr_val;
    end
    assign state_flat[3*g +: 3] = st_q[g];
  end

  always_comb begin
    walk_state  = '0;
    query_state = '0;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (walk_idx  == IDX_W'(i)) walk_state  = st_q[i];
      if (query_idx == IDX_W'(i)) query_state = st_q[i];
    end
  end

endmodule

// File: rtl/wp_walk_ctrl.sv
module wp_walk_ctrl
  import wp_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  input  logic [OP_W-1:0]               cmd_op,
  input  logic [$clog2(NUM_BLOCKS)-1:0] range_lo,
  input  logic [$clog2(NUM_BLOCKS)-1:0] range_hi,
  input  wp_enc_t                       cur_state,
  output logic [$clog2(NUM_BLOCKS)-1:0] blk_idx,
  output logic                          wr_en,
  output wp_enc_t                       wr_val,
  output logic                          busy,
  output logic [OP_W-1:0]               op_cur,
  output logic                          done,
  output logic                          err,
  output logic [STAT_W-1:0]             status
);
  localparam int IDX_W = $clog2(NUM_BLOCKS);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLOCKS - 1);

  logic             busy_q, done_q, err_q;
  logic [OP_W-1:0]  op_q;
  logic [IDX_W-1:0] idx_q, end_q;
  logic [STAT_W-1:0] status_q;

  logic    accept, past_end, out_of_array, finish;
  wp_act_e act;

  assign accept       = cmd_valid && !busy_q && op_known(cmd_op);
  assign past_end     = idx_q > end_q;
  assign out_of_array = {1'b0, idx_q} >= CNT_W'(NUM_BLOCKS);
  assign act          = op_action(op_q, cur_state);

  assign wr_en  = busy_q && !past_end && !out_of_array && (act == ACT_WRITE);
  assign wr_val = op_target(op_q);
  assign finish = busy_q && (past_end || out_of_array ||
                             (act == ACT_STOP) || (idx_q == end_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      op_q     <= '0;
      idx_q    <= '0;
      end_q    <= '0;
      status_q <= STAT_W'(ENC_LOCKED);
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        op_q   <= cmd_op;
        idx_q  <= (cmd_op == OP_UNLOCK_ALL) ? '0 : range_lo;
        end_q  <= (cmd_op == OP_UNLOCK_ALL) ? LAST_IDX : range_hi;
      end else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        err_q  <= out_of_array && !past_end;
      end else if (busy_q) begin
        idx_q <= idx_q + 1'b1;
      end
      if (wr_en) status_q <= STAT_W'(wr_val);
    end
  end

  assign blk_idx = idx_q;
  assign busy    = busy_q;
  assign op_cur  = op_q;
  assign done    = done_q;
  assign err     = err_q;
  assign status  = status_q;

endmodule

// File: rtl/wp_lock_mgr.sv
module wp_lock_mgr
  import wp_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int RANGE_W    = 16,
  localparam int IDX_W     = $clog2(NUM_BLOCKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lo_we,
  input  logic               hi_we,
  input  logic [RANGE_W-1:0] range_wdata,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_op,
  input  logic [IDX_W-1:0]   query_idx,
  output logic [2:0]         query_state,
  output logic [IDX_W-1:0]   range_lo,
  output logic [IDX_W-1:0]   range_hi,
  output logic [15:0]        wp_status,
  output logic               walk_done,
  output logic               cmd_err
);
  // Named internal events for the checker
  logic                    walk_busy;
  logic [OP_W-1:0]         walk_op;
  logic                    blk_wr_en;
  logic [IDX_W-1:0]        blk_idx;
  wp_enc_t                 blk_wr_val;
  wp_enc_t                 blk_cur;
  logic [3*NUM_BLOCKS-1:0] state_flat;

  wp_range_regs #(.NUM_BLOCKS(NUM_BLOCKS), .RANGE_W(RANGE_W)) u_range (
    .clk   (clk),
    .rst_n (rst_n),
    .lo_we (lo_we),
    .hi_we (hi_we),
    .wdata (range_wdata),
    .lo_q  (range_lo),
    .hi_q  (range_hi)
  );

  wp_walk_ctrl #(.NUM_BLOCKS(NUM_BLOCKS)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .range_lo  (range_lo),
    .range_hi  (range_hi),
    .cur_state (blk_cur),
    .blk_idx   (blk_idx),
    .wr_en     (blk_wr_en),
    .wr_val    (blk_wr_val),
    .busy      (walk_busy),
    .op_cur    (walk_op),
    .done      (walk_done),
    .err       (cmd_err),
    .status    (wp_status)
  );

  wp_state_array #(.NUM_BLOCKS(NUM_BLOCKS)) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (blk_wr_en),
    .wr_idx      (blk_idx),
    .wr_val      (blk_wr_val),
    .walk_idx    (blk_idx),
    .walk_state  (blk_cur),
    .query_idx   (query_idx),
    .query_state (query_state),
    .state_flat  (state_flat)
  );

endmodule

// File: rtl/wp_lock_checker.sv
module wp_lock_checker
  import wp_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic                    walk_busy,
  input logic [OP_W-1:0]         walk_op,
  input logic                    walk_done,
  input logic                    cmd_err,
  input logic [15:0]             wp_status,
  input logic [3*NUM_BLOCKS-1:0] state_flat
);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> !walk_busy);

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_err) |-> walk_done);

  assert_status_enc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wp_status) == 1) && (wp_status < 16'd8));

  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_busy && cmd_valid) |=> $stable(walk_op));

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk_chk
    assert_enc_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state_flat[3*g +: 3]) == 1);
    assert_tight_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_flat[3*g +: 3] == ENC_TIGHT) |=> (state_flat[3*g +: 3] == ENC_TIGHT));
  end

endmodule

bind wp_lock_mgr wp_lock_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .walk_busy  (walk_busy),
  .walk_op    (walk_op),
  .walk_done  (walk_done),
  .cmd_err    (cmd_err),
  .wp_status  (wp_status),
  .state_flat (state_flat)
);

// File: tb/tb_wp_lock_mgr.sv
`timescale 1ns/1ps
module tb_wp_lock_mgr;
  localparam int NB    = 12;
  localparam int RW    = 16;
  localparam int IW    = 4;
  localparam int NIDX  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lo_we = 1'b0, hi_we = 1'b0;
  logic [RW-1:0] range_wdata = '0;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_op = '0;
  logic [IW-1:0] query_idx = '0;
  logic [2:0]    query_state;
  logic [IW-1:0] range_lo, range_hi;
  logic [15:0]   wp_status;
  logic          walk_done, cmd_err;

  always #4 clk = ~clk;

  wp_lock_mgr #(.NUM_BLOCKS(NB), .RANGE_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .lo_we(lo_we), .hi_we(hi_we),
    .range_wdata(range_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .query_idx(query_idx), .query_state(query_state),
    .range_lo(range_lo), .range_hi(range_hi), .wp_status(wp_status),
    .walk_done(walk_done), .cmd_err(cmd_err)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [2:0] m_st [NB];
  int m_status, m_err, m_lat;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) m_st[i] = 3'b010;
    m_status = 2; m_err = 0;
  endtask

  // Expected outcome computed from the walk rules (R3-R10)
  task automatic model_cmd(input logic [7:0] op, input int s, input int e);
    int lo, hi, b;
    logic [2:0] tgt;
    lo = (op == 8'h27) ? 0 : s;
    hi = (op == 8'h27) ? NB - 1 : e;
    tgt = (op == 8'h2A) ? 3'b010 : (op == 8'h2C) ? 3'b001 : 3'b100;
    m_err = 0; m_lat = 0; b = lo;
    forever begin
      m_lat++;
      if (b > hi) break;
      if (b >= NB) begin m_err = 1; break; end
      if (op == 8'h2C) begin
        if (m_st[b] != 3'b100) begin m_st[b] = tgt; m_status = tgt; end
      end else begin
        if (m_st[b] == 3'b001) break;
        m_st[b] = tgt; m_status = tgt;
      end
      if (b == hi) break;
      b++;
    end
  endtask

  task automatic check_states(input string req);
    int bad_i;
    bad_i = -1;
    for (int i = 0; i < NIDX; i++) begin
      query_idx = IW'(i);
      #0.1;
      if (i < NB) begin
        if (query_state != m_st[i] && bad_i < 0) bad_i = i;
      end else if (query_state != 3'b000 && bad_i < 0) bad_i = i;
    end
    if (bad_i < 0) chk(req, "block states", 0, 0);
    else begin
      query_idx = IW'(bad_i);
      #0.1;
      chk(req, $sformatf("block %0d state", bad_i), query_state,
          (bad_i < NB) ? m_st[bad_i] : 0);
    end
  endtask

  task automatic set_range(input int s, input int e, input int salt);
    @(negedge clk);
    lo_we = 1; range_wdata = RW'(s + NIDX * salt);
    @(negedge clk);
    lo_we = 0;
    chk("R2", "lo after start write", range_lo, s);
    chk("R2", "hi copied on start write", range_hi, s);
    hi_we = 1; range_wdata = RW'(e + NIDX * (salt + 3));
    @(negedge clk);
    hi_we = 0;
    chk("R2", "lo kept on end write", range_lo, s);
    chk("R2", "hi after end write", range_hi, e);
  endtask

  task automatic run_cmd(input logic [7:0] op, input int s, input int e, input string req);
    int cnt;
    model_cmd(op, s, e);
    cmd_valid = 1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 0;
    chk("R10", "done too early", walk_done, 0);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!walk_done && cnt < 40);
    chk("R10", "done latency", cnt, m_lat);
    chk("R8", "cmd_err", cmd_err, m_err);
    chk("R9", "wp_status", wp_status, m_status);
    check_states(req);
    @(negedge clk);
    chk("R10", "done single pulse", walk_done, 0);
  endtask

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'h23: return "R3";
      8'h2A: return "R4";
      8'h27: return "R5";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "wp_status reset", wp_status, 2);
    chk("R1", "done reset", walk_done, 0);
    chk("R1", "err reset", cmd_err, 0);
    chk("R1", "range_lo reset", range_lo, 0);
    chk("R1", "range_hi reset", range_hi, 0);
    check_states("R1");
    rst_n = 1;
    @(negedge clk);

    // R11: ignored opcode
    cmd_valid = 1; cmd_op = 8'h55;
    @(negedge clk);
    cmd_valid = 0;
    begin
      int seen;
      seen = 0;
      repeat (6) begin @(negedge clk); if (walk_done) seen = 1; end
      chk("R11", "done on unknown opcode", seen, 0);
    end
    check_states("R11");

    // R11: command during a walk is ignored
    set_range(0, 11, 1);
    model_cmd(8'h23, 0, 11);
    cmd_valid = 1; cmd_op = 8'h23;
    @(negedge clk);
    cmd_op = 8'h2A;
    @(negedge clk);
    cmd_valid = 0;
    begin
      int cnt, extra;
      cnt = 1; extra = 0;
      while (!walk_done && cnt < 40) begin @(negedge clk); cnt++; end
      chk("R11", "walk latency with busy strobe", cnt, m_lat);
      repeat (16) begin @(negedge clk); if (walk_done) extra = 1; end
      chk("R11", "second walk after busy strobe", extra, 0);
    end
    check_states("R11");

    // Pass 1: unlock / lock / unlock-all over every range pair
    for (int s = 0; s < NIDX; s++) begin
      for (int e = 0; e < NIDX; e++) begin
        logic [7:0] op;
        case ((s * 5 + e) % 3)
          0: op = 8'h23;
          1: op = 8'h2A;
          default: op = 8'h27;
        endcase
        set_range(s, e, (s + e) % 7);
        run_cmd(op, s, e, req_of(op));
      end
    end

    // Fresh cold reset for pass 2
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    model_reset();
    chk("R1", "wp_status after second reset", wp_status, 2);
    check_states("R1");
    rst_n = 1;

    // Pass 2: lock-tight mixed in; stop and skip rules (R6, R7)
    for (int s = 0; s < NIDX; s++) begin
      for (int e = 0; e < NIDX; e++) begin
        logic [7:0] op;
        case ((s * 3 + e * 7) % 11)
          0: op = 8'h2C;
          1, 2, 3: op = 8'h2A;
          4, 5: op = 8'h27;
          default: op = 8'h23;
        endcase
        set_range(s, e, (s * e) % 5);
        run_cmd(op, s, e, (op == 8'h2C) ? "R7" : "R6");
      end
    end

    finish_run();
  end

endmodule